// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block translates instruction-fetch addresses. When translation is enabled, a 64-bit effective fetch address is looked up in a small direct-mapped table. On a hit, the block produces a 56-bit real address made from the stored page number and the untranslated page offset. When translation is disabled, the low 56 bits of the fetch address pass straight through and the access is always allowed. Each stored entry carries a privilege bit. A fetch made outside privileged mode that hits an entry with that bit set is reported as a privilege fault.

The table slot is chosen by folding three 6-bit fields of the page number together with XOR, not by taking the low page-number bits. This spreads pages that are far apart across different slots. The update side fills a slot from a translation and its page-table entry. It can also drop a single slot, chosen by hashing the command address, without comparing tags. A third command drops every slot at once. A sticky fetch-failed flag records any requested fetch that could not proceed. It stays set until reset, a pipeline flush or a table fill.

The lookup path is combinational from the fetch inputs. Updates and the sticky flag change on the rising clock edge.

Top module: `itlb_xlate`

## Requirements
- R1: Reset (`rst` high at a rising edge) clears every slot's valid bit. After reset, every translated fetch reports `ra_valid`=0 and `fetch_failed`=0.
- R2: The slot index is bits 17:12 XOR bits 23:18 XOR bits 29:24 of the address. The lookup uses `fetch_ea` for this and the update side uses `upd_ea`.
- R3: With `xlate_on`=1, `ra_valid` is 1 only when the indexed slot is valid and its stored tag equals `fetch_ea[63:18]`. A fill into a slot replaces whatever it held before.
- R4: With `xlate_on`=1 and a hit, `real_addr` is the stored page-table entry bits 55:12 followed by `fetch_ea[11:0]`.
- R5: With `xlate_on`=0, `real_addr` = `fetch_ea[55:0]`, `ra_valid`=1 and `priv_fault`=0, whatever the table holds.
- R6: With `xlate_on`=1, `priv_fault` is 1 when bit 3 of the indexed entry's page-table entry is 1 and `priv_mode`=0. With `priv_mode`=1 there is no fault.
- R7: `access_ok` is 1 exactly when `ra_valid`=1 and `priv_fault`=0. A miss is therefore never OK.
- R8: `upd_inval` with `upd_ea[11:10]`=00 clears only the valid bit of the slot hashed from `upd_ea`. It does this even when the tag stored there differs from `upd_ea[63:18]`.
- R9: `upd_inval` with `upd_ea[11:10]` not 00 clears every slot's valid bit.
- R10: Update priority at one edge, highest first: reset or drop-all, then single drop, then fill. A fill writes the tag, page number, privilege bit and valid bit of the hashed slot.
- R11: `fetch_failed` is set at an edge where `fetch_req`=1 and `access_ok`=0. It holds until an edge with `rst`, `flush` or `upd_load` high. A clear wins over a set at the same edge.
- R12: A fill or drop is seen by the lookup in the cycle after the edge that applies it, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | A fetch is being requested this cycle |
| fetch_ea | input | 64 | Effective fetch address |
| xlate_on | input | 1 | Translate the fetch address through the table |
| priv_mode | input | 1 | The fetch is made in privileged mode |
| flush | input | 1 | Pipeline flush; clears the sticky flag |
| upd_load | input | 1 | Fill the hashed slot from `upd_ea` / `upd_pte` |
| upd_inval | input | 1 | Drop one slot, or all slots when `upd_ea[11:10]` is not 00 |
| upd_ea | input | 64 | Effective address for the update command |
| upd_pte | input | 64 | Page-table entry for a fill |
| real_addr | output | 56 | Translated real address |
| ra_valid | output | 1 | Real address is valid (hit, or translation off) |
| priv_fault | output | 1 | Privilege violation on this fetch |
| access_ok | output | 1 | Valid and no fault |
| fetch_failed | output | 1 | Sticky record of a failed fetch request |

## Verification
The bench fills two addresses whose three fields fold to the same slot. It expects the second fill to evict the first. A design that indexed by the low page bits alone, or that skipped the tag compare, would keep both or report a false hit. A single drop is issued with an address that hashes to an occupied slot but carries a different tag; a design that compared tags before dropping would leave the entry live. Drop-all is set apart from a single drop by the two scope bits, and a drop is issued in the same cycle as a fill. A wrong priority would leave a live entry that the bench then hits. The bench checks privilege faults in both modes, and fetches with translation off against an entry that carries the privilege bit. It also exercises the sticky flag's set, hold, clear-beats-set and reset paths; a flag that was not sticky, or that set on a cycle with no request, shows up at once.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  // Update command after priority decode
  typedef enum logic [1:0] {
    UPD_IDLE     = 2'd0,
    UPD_FILL     = 2'd1,
    UPD_DROP_ONE = 2'd2,
    UPD_DROP_ALL = 2'd3
  } upd_kind_e;

  // Privilege check on a translated fetch
  function automatic logic prv_violation(input logic entry_prv, input logic sup_mode);
    return entry_prv & ~sup_mode;
  endfunction

  // Access permission from validity and fault
  function automatic logic grant(input logic valid, input logic fault);
    return valid & ~fault;
  endfunction

endpackage

// File: rtl/itlb_hash.sv
module itlb_hash #(
  parameter int IDX_BITS = 6,
  parameter int FOLDS    = 3,
  localparam int FIELD_W = IDX_BITS * FOLDS
) (
  input  logic [FIELD_W-1:0]  fields,
  output logic [IDX_BITS-1:0] idx
);

  logic [IDX_BITS-1:0] acc [FOLDS+1];

  assign acc[0] = '0;

  for (genvar f = 0; f < FOLDS; f++) begin : g_fold
    assign acc[f+1] = acc[f] ^ fields[f*IDX_BITS +: IDX_BITS];
  end

  assign idx = acc[FOLDS];

endmodule

// File: rtl/itlb_upd_dec.sv
module itlb_upd_dec
  import itlb_pkg::*;
#(
  parameter int SCOPE_W = 2
) (
  input  logic               load,
  input  logic               inval,
  input  logic [SCOPE_W-1:0] scope,
  output upd_kind_e          kind
);

  always_comb begin
    if (inval) begin
      kind = (|scope) ? UPD_DROP_ALL : UPD_DROP_ONE;
    end else if (load) begin
      kind = UPD_FILL;
    end else begin
      kind = UPD_IDLE;
    end
  end

endmodule

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int IDX_BITS = 6,
  parameter int TAG_BITS = 46,
  parameter int PPN_BITS = 44
) (
  input  logic                clk,
  input  logic                rst,
  input  upd_kind_e           kind,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_BITS-1:0] wr_tag,
  input  logic [PPN_BITS-1:0] wr_ppn,
  input  logic                wr_prv,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [TAG_BITS-1:0] rd_tag,
  output logic [PPN_BITS-1:0] rd_ppn,
  output logic                rd_prv
);

  logic [ENTRIES-1:0]  vld;
  logic [ENTRIES-1:0]  prv;
  logic [TAG_BITS-1:0] tags [ENTRIES];
  logic [PPN_BITS-1:0] ppns [ENTRIES];

  // Valid bits: reset / drop-all, then single drop, then fill
  always_ff @(posedge clk) begin
    if (rst || kind == UPD_DROP_ALL) begin
      vld <= '0;
    end else if (kind == UPD_DROP_ONE) begin
      vld[wr_idx] <= 1'b0;
    end else if (kind == UPD_FILL) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  // Payload: no reset, written only by a fill
  always_ff @(posedge clk) begin
    if (!rst && kind == UPD_FILL) begin
      tags[wr_idx] <= wr_tag;
      ppns[wr_idx] <= wr_ppn;
      prv[wr_idx]  <= wr_prv;
    end
  end

  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tags[rd_idx];
  assign rd_ppn   = ppns[rd_idx];
  assign rd_prv   = prv[rd_idx];

endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int RA_BITS   = 56,
  parameter int PAGE_BITS = 12,
  parameter int TAG_BITS  = 46,
  localparam int PPN_BITS = RA_BITS - PAGE_BITS
) (
  input  logic                xlate_on,
  input  logic                sup_mode,
  input  logic [RA_BITS-1:0]  ea_low,
  input  logic [TAG_BITS-1:0] ea_tag,
  input  logic                ent_valid,
  input  logic [TAG_BITS-1:0] ent_tag,
  input  logic [PPN_BITS-1:0] ent_ppn,
  input  logic                ent_prv,
  output logic [RA_BITS-1:0]  real_addr,
  output logic                ra_valid,
  output logic                priv_fault,
  output logic                access_ok
);

  logic tag_hit;
  logic eff_prv;

  assign tag_hit = ent_valid && (ent_tag == ea_tag);

  always_comb begin
    if (xlate_on) begin
      real_addr = {ent_ppn, ea_low[PAGE_BITS-1:0]};
      ra_valid  = tag_hit;
      eff_prv   = ent_prv;
    end else begin
      real_addr = ea_low;
      ra_valid  = 1'b1;
      eff_prv   = 1'b0;
    end
  end

  assign priv_fault = prv_violation(eff_prv, sup_mode);
  assign access_ok  = grant(ra_valid, priv_fault);

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int EA_BITS   = 64,
  parameter int RA_BITS   = 56,
  parameter int PTE_BITS  = 64,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 64,
  parameter int PRV_BIT   = 3,
  parameter int SCOPE_LSB = 10,
  parameter int SCOPE_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_req,
  input  logic [EA_BITS-1:0]  fetch_ea,
  input  logic                xlate_on,
  input  logic                priv_mode,
  input  logic                flush,
  input  logic                upd_load,
  input  logic                upd_inval,
  input  logic [EA_BITS-1:0]  upd_ea,
  input  logic [PTE_BITS-1:0] upd_pte,
  output logic [RA_BITS-1:0]  real_addr,
  output logic                ra_valid,
  output logic                priv_fault,
  output logic                access_ok,
  output logic                fetch_failed
);

  localparam int IDX_BITS = $clog2(ENTRIES);
  localparam int FOLDS    = 3;
  localparam int FIELD_W  = FOLDS * IDX_BITS;
  localparam int TAG_LSB  = PAGE_BITS + IDX_BITS;
  localparam int TAG_BITS = EA_BITS - TAG_LSB;
  localparam int PPN_BITS = RA_BITS - PAGE_BITS;

  // Named internal events for the checker
  logic [IDX_BITS-1:0] fetch_idx;
  logic [IDX_BITS-1:0] upd_idx;
  upd_kind_e           upd_kind;
  logic                ff_set_evt;
  logic                ff_clr_evt;

  logic                ent_valid;
  logic [TAG_BITS-1:0] ent_tag;
  logic [PPN_BITS-1:0] ent_ppn;
  logic                ent_prv;
  logic                fetch_failed_q;

  // Only the fields used below are decoded from the update inputs
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{upd_ea, upd_pte};

  itlb_hash #(.IDX_BITS(IDX_BITS), .FOLDS(FOLDS)) u_hash_fetch (
    .fields (fetch_ea[PAGE_BITS +: FIELD_W]),
    .idx    (fetch_idx)
  );

  itlb_hash #(.IDX_BITS(IDX_BITS), .FOLDS(FOLDS)) u_hash_upd (
    .fields (upd_ea[PAGE_BITS +: FIELD_W]),
    .idx    (upd_idx)
  );

  itlb_upd_dec #(.SCOPE_W(SCOPE_W)) u_dec (
    .load  (upd_load),
    .inval (upd_inval),
    .scope (upd_ea[SCOPE_LSB +: SCOPE_W]),
    .kind  (upd_kind)
  );

  itlb_store #(
    .ENTRIES  (ENTRIES),
    .IDX_BITS (IDX_BITS),
    .TAG_BITS (TAG_BITS),
    .PPN_BITS (PPN_BITS)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .kind     (upd_kind),
    .wr_idx   (upd_idx),
    .wr_tag   (upd_ea[EA_BITS-1:TAG_LSB]),
    .wr_ppn   (upd_pte[RA_BITS-1:PAGE_BITS]),
    .wr_prv   (upd_pte[PRV_BIT]),
    .rd_idx   (fetch_idx),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_ppn   (ent_ppn),
    .rd_prv   (ent_prv)
  );

  itlb_lookup #(
    .RA_BITS   (RA_BITS),
    .PAGE_BITS (PAGE_BITS),
    .TAG_BITS  (TAG_BITS)
  ) u_lookup (
    .xlate_on   (xlate_on),
    .sup_mode   (priv_mode),
    .ea_low     (fetch_ea[RA_BITS-1:0]),
    .ea_tag     (fetch_ea[EA_BITS-1:TAG_LSB]),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_ppn    (ent_ppn),
    .ent_prv    (ent_prv),
    .real_addr  (real_addr),
    .ra_valid   (ra_valid),
    .priv_fault (priv_fault),
    .access_ok  (access_ok)
  );

  // Sticky failure flag; a clear wins over a set
  assign ff_set_evt = fetch_req && !access_ok;
  assign ff_clr_evt = rst || flush || upd_load;

  always_ff @(posedge clk) begin
    if (ff_clr_evt) begin
      fetch_failed_q <= 1'b0;
    end else if (ff_set_evt) begin
      fetch_failed_q <= 1'b1;
    end
  end

  assign fetch_failed = fetch_failed_q;

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk
  import itlb_pkg::*;
#(
  parameter int EA_BITS   = 64,
  parameter int RA_BITS   = 56,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6,
  parameter int SCOPE_LSB = 10,
  parameter int SCOPE_W   = 2,
  localparam int TAG_LSB  = PAGE_BITS + IDX_BITS
) (
  input logic                clk,
  input logic                rst,
  input logic                fetch_req,
  input logic [EA_BITS-1:0]  fetch_ea,
  input logic                xlate_on,
  input logic                priv_mode,
  input logic                flush,
  input logic                upd_load,
  input logic                upd_inval,
  input logic [EA_BITS-1:0]  upd_ea,
  input logic [RA_BITS-1:0]  real_addr,
  input logic                ra_valid,
  input logic                priv_fault,
  input logic                access_ok,
  input logic                fetch_failed,
  input logic [IDX_BITS-1:0] fetch_idx,
  input logic [IDX_BITS-1:0] upd_idx,
  input upd_kind_e           upd_kind
);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!xlate_on || !ra_valid));

  assert_fill_hit_R12: assert property (@(posedge clk) disable iff (rst)
    (upd_kind == UPD_FILL) |=>
      ((xlate_on && fetch_idx == $past(upd_idx) &&
        fetch_ea[EA_BITS-1:TAG_LSB] == $past(upd_ea[EA_BITS-1:TAG_LSB])) -> ra_valid));

  assert_page_offset_R4: assert property (@(posedge clk) disable iff (rst)
    xlate_on |-> (real_addr[PAGE_BITS-1:0] == fetch_ea[PAGE_BITS-1:0]));

  assert_xlate_off_R5: assert property (@(posedge clk) disable iff (rst)
    !xlate_on |-> (ra_valid && !priv_fault && real_addr == fetch_ea[RA_BITS-1:0]));

  assert_fault_mode_R6: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> (xlate_on && !priv_mode));

  assert_ok_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
    access_ok |-> (ra_valid && !priv_fault));

  assert_drop_one_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_inval && upd_ea[SCOPE_LSB +: SCOPE_W] == '0) |=>
      ((xlate_on && fetch_idx == $past(upd_idx)) -> !ra_valid));

  assert_drop_all_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_inval && upd_ea[SCOPE_LSB +: SCOPE_W] != '0) |=> (xlate_on -> !ra_valid));

  assert_drop_beats_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_inval && upd_load) |=>
      ((xlate_on && fetch_idx == $past(upd_idx)) -> !ra_valid));

  assert_ff_set_R11: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !access_ok && !flush && !upd_load) |=> fetch_failed);

  assert_ff_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (flush || upd_load) |=> !fetch_failed);

  assert_ff_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (fetch_failed && !flush && !upd_load) |=> fetch_failed);

endmodule

bind itlb_xlate itlb_xlate_chk #(
  .EA_BITS   (EA_BITS),
  .RA_BITS   (RA_BITS),
  .PAGE_BITS (PAGE_BITS),
  .IDX_BITS  (IDX_BITS),
  .SCOPE_LSB (SCOPE_LSB),
  .SCOPE_W   (SCOPE_W)
) u_itlb_xlate_chk (
  .clk          (clk),
  .rst          (rst),
  .fetch_req    (fetch_req),
  .fetch_ea     (fetch_ea),
  .xlate_on     (xlate_on),
  .priv_mode    (priv_mode),
  .flush        (flush),
  .upd_load     (upd_load),
  .upd_inval    (upd_inval),
  .upd_ea       (upd_ea),
  .real_addr    (real_addr),
  .ra_valid     (ra_valid),
  .priv_fault   (priv_fault),
  .access_ok    (access_ok),
  .fetch_failed (fetch_failed),
  .fetch_idx    (fetch_idx),
  .upd_idx      (upd_idx),
  .upd_kind     (upd_kind)
);

// File: tb/test_itlb_xlate.sv
`timescale 1ns/1ps
module test_itlb_xlate;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_req;
  logic [63:0] fetch_ea;
  logic        xlate_on;
  logic        priv_mode;
  logic        flush;
  logic        upd_load;
  logic        upd_inval;
  logic [63:0] upd_ea;
  logic [63:0] upd_pte;
  logic [55:0] real_addr;
  logic        ra_valid;
  logic        priv_fault;
  logic        access_ok;
  logic        fetch_failed;

  always #10 clk = ~clk;  // 50 MHz

  itlb_xlate i_itlb_xlate (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ea(fetch_ea),
    .xlate_on(xlate_on), .priv_mode(priv_mode), .flush(flush),
    .upd_load(upd_load), .upd_inval(upd_inval), .upd_ea(upd_ea), .upd_pte(upd_pte),
    .real_addr(real_addr), .ra_valid(ra_valid), .priv_fault(priv_fault),
    .access_ok(access_ok), .fetch_failed(fetch_failed)
  );

  typedef struct {
    string       req;
    logic [55:0] ra;
    logic        v;
    logic        pf;
    logic        ok;
    logic        ff;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  // Reference model state
  logic        m_v   [64];
  logic [45:0] m_tag [64];
  logic [63:0] m_pte [64];
  logic        m_ff;

  // Bit-serial restatement of the slot hash (R2)
  function automatic logic [5:0] ref_idx(input logic [63:0] a);
    logic [5:0] h = '0;
    for (int b = 0; b < 18; b++) h[b % 6] = h[b % 6] ^ a[12 + b];
    return h;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_pte[i] = '0;
    end
  endtask

  // Driver: apply one vector, queue its expectation, then advance the model
  task automatic drive(input string r, input logic fr, input logic [63:0] ea,
                       input logic xon, input logic pm, input logic ld, input logic inv,
                       input logic [63:0] uea, input logic [63:0] upte,
                       input logic fl, input logic rs);
    exp_t e;
    logic [5:0] i;
    @(negedge clk);
    fetch_req = fr; fetch_ea = ea; xlate_on = xon; priv_mode = pm;
    upd_load = ld; upd_inval = inv; upd_ea = uea; upd_pte = upte;
    flush = fl; rst = rs;
    #2;
    i = ref_idx(ea);
    e.req = r;
    if (xon) begin
      e.v  = m_v[i] && (m_tag[i] == ea[63:18]);
      e.ra = {m_pte[i][55:12], ea[11:0]};
      e.pf = m_pte[i][3] & ~pm;
    end else begin
      e.v  = 1'b1;
      e.ra = ea[55:0];
      e.pf = 1'b0;
    end
    e.ok = e.v & ~e.pf;
    e.ff = m_ff;
    exp_q.push_back(e);
    @(posedge clk);
    if (rs || (inv && uea[11:10] != 2'b00)) begin
      for (int k = 0; k < 64; k++) m_v[k] = 1'b0;
    end else if (inv) begin
      m_v[ref_idx(uea)] = 1'b0;
    end else if (ld) begin
      m_v[ref_idx(uea)]   = 1'b1;
      m_tag[ref_idx(uea)] = uea[63:18];
      m_pte[ref_idx(uea)] = upte;
    end
    if (rs || fl || ld) m_ff = 1'b0;
    else if (fr && !e.ok) m_ff = 1'b1;
  endtask

  task automatic miscompare(input string r, input string f, input logic [63:0] a, input logic [63:0] x);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h", r, f, a, x);
  endtask

  // Monitor: pop each expectation and compare against the outputs
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_vec++;
      if (ra_valid !== e.v) miscompare(e.req, "ra_valid", 64'(ra_valid), 64'(e.v));
      if (access_ok !== e.ok) miscompare(e.req, "access_ok", 64'(access_ok), 64'(e.ok));
      if (fetch_failed !== e.ff) miscompare(e.req, "fetch_failed", 64'(fetch_failed), 64'(e.ff));
      if (e.v) begin
        if (real_addr !== e.ra) miscompare(e.req, "real_addr", 64'(real_addr), 64'(e.ra));
        if (priv_fault !== e.pf) miscompare(e.req, "priv_fault", 64'(priv_fault), 64'(e.pf));
      end
    end
  end

  task automatic report_and_end();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_and_end();
  end

  localparam logic [63:0] EA_A   = 64'h0000_0000_0000_1000; // slot 1
  localparam logic [63:0] EA_B   = 64'h0000_0000_0004_0000; // slot 1, other tag
  localparam logic [63:0] EA_C   = 64'hFFFF_8000_1234_5678;
  localparam logic [63:0] PTE_U  = 64'h00AB_CDEF_0123_4000;  // bit 3 clear
  localparam logic [63:0] PTE_P  = 64'h0011_2233_4455_6008;  // bit 3 set
  localparam logic [63:0] ALL_EA = 64'h0000_0000_0000_0400;  // scope bits 01
  localparam logic [63:0] Z      = 64'h0;

  initial begin
    rst = 1'b1; fetch_req = 0; fetch_ea = '0; xlate_on = 0; priv_mode = 0;
    flush = 0; upd_load = 0; upd_inval = 0; upd_ea = '0; upd_pte = '0;
    clear_model();
    m_ff = 1'b0;
    repeat (3) @(posedge clk);

    //           req    fr  ea     xon pm ld inv uea     upte   fl rs
    drive("R1",  1, EA_A, 1, 0, 0, 0, Z,     Z,     0, 0); // empty after reset, sets ff
    drive("R11", 0, EA_A, 1, 0, 0, 0, Z,     Z,     0, 0); // ff held, no request: no new set
    drive("R11", 0, EA_A, 1, 0, 0, 0, Z,     Z,     1, 0); // flush clears
    drive("R12", 1, EA_A, 1, 0, 1, 0, EA_A,  PTE_U, 0, 0); // fill not visible yet
    drive("R4",  1, EA_A, 1, 0, 0, 0, Z,     Z,     0, 0); // hit, translated address
    drive("R12", 0, EA_C, 1, 1, 1, 0, EA_C,  PTE_P, 0, 0);
    drive("R6",  1, EA_C, 1, 1, 0, 0, Z,     Z,     0, 0); // privileged: no fault
    drive("R6",  1, EA_C, 1, 0, 0, 0, Z,     Z,     0, 0); // user: fault
    drive("R11", 1, EA_C, 1, 1, 0, 0, Z,     Z,     0, 0); // sticky while access ok
    drive("R3",  1, EA_B, 1, 1, 0, 0, Z,     Z,     0, 0); // alias miss, tag differs
    drive("R2",  0, EA_B, 1, 1, 1, 0, EA_B,  PTE_U, 0, 0); // fill alias into same slot
    drive("R3",  0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0); // A evicted
    drive("R2",  0, EA_B, 1, 1, 0, 0, Z,     Z,     0, 0); // B hits
    drive("R7",  0, EA_C, 1, 0, 0, 0, Z,     Z,     0, 0); // fault: not ok
    drive("R8",  0, EA_B, 1, 1, 0, 1, EA_A,  Z,     0, 0); // drop with other tag
    drive("R8",  0, EA_B, 1, 1, 0, 0, Z,     Z,     0, 0); // B gone
    drive("R8",  0, EA_C, 1, 1, 0, 0, Z,     Z,     0, 0); // other slot untouched
    drive("R10", 0, EA_A, 1, 1, 1, 1, EA_A,  PTE_U, 0, 0); // drop beats fill
    drive("R10", 0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0);
    drive("R10", 0, EA_A, 1, 1, 1, 0, EA_A,  PTE_U, 0, 0);
    drive("R10", 0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0); // plain fill hits
    drive("R9",  0, EA_A, 1, 1, 1, 1, ALL_EA, PTE_U, 0, 0); // drop-all beats fill
    drive("R9",  0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0);
    drive("R9",  0, EA_C, 1, 1, 0, 0, Z,     Z,     0, 0);
    drive("R5",  0, EA_C, 1, 1, 1, 0, EA_C,  PTE_P, 0, 0);
    drive("R5",  1, EA_C, 0, 0, 0, 0, Z,     Z,     0, 0); // translation off, user mode
    drive("R5",  1, EA_B, 0, 0, 0, 0, Z,     Z,     0, 0);
    drive("R11", 1, EA_A, 1, 1, 0, 0, Z,     Z,     1, 0); // clear beats set
    drive("R11", 1, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0); // miss sets
    drive("R11", 0, EA_A, 1, 1, 1, 0, EA_A,  PTE_U, 0, 0); // fill clears
    drive("R11", 1, EA_B, 1, 1, 0, 0, Z,     Z,     0, 0); // sets again
    drive("R1",  0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 1); // reset edge
    drive("R1",  0, EA_A, 1, 1, 0, 0, Z,     Z,     0, 0); // A dropped, ff cleared
    drive("R1",  0, EA_C, 1, 1, 0, 0, Z,     Z,     0, 0);

    wait (exp_q.size() == 0);
    #1;
    report_and_end();
  end

endmodule